// File: doc/BRIEF.md
# Port Current Supervisor Timers

This block watches a powered Ethernet power-sourcing port through digitized current comparator flags and tells the port sequencer when power must be removed. It runs two timers. The overload timer measures how long the port current stays above the cut threshold. The disconnect timer measures how long the powered device has failed to show its maintain-power signature. When either timer expires, the block issues a one-cycle request. The analog current limit is not part of this block.

The disconnect timer has two sense modes, chosen by an input. In DC mode it reads an undercurrent flag once per clock. A presence filter makes sure that only sustained current clears the timer. In AC mode it advances only on sample strobes, one strobe per cycle of the probe tone, and a single good sample does not clear it. The block also picks a cut-threshold code for the analog overcurrent comparator. The code depends on the latched power class and on a class-enforcement input.

Both timers are held cleared while the port is off. All limits are parameters counted in clock cycles, or in samples for AC mode.

Top module: `psup_top`

## Requirements
- R1: With `enforce_i` high, `cut_code_o` is 2'b01 (low, about 100 mA) for class 1, 2'b10 (medium, about 175 mA) for class 2, and 2'b00 (full, about 375 mA) for classes 0, 3 and 4. The code is combinational from the inputs.
- R2: With `enforce_i` low, `cut_code_o` is 2'b00 for every class.
- R3: While the port is on, the OVL_LIMIT-th consecutive clock edge that samples `over_cut_i` high raises `ovl_fault_o` in the cycle that follows that edge.
- R4: One edge that samples `over_cut_i` low restarts the overload count from zero, so a new run of OVL_LIMIT high edges is needed before a fault.
- R5: In DC mode (`ac_mode_i` = 0), the DC_LIMIT-th edge that samples `dc_under_i` high raises `disc_o`. Absent edges accumulate until the timer is cleared.
- R6: In DC mode the disconnect count is cleared only by PRESENCE_CYCLES consecutive edges that sample `dc_under_i` low. A shorter run of presence holds the count, and counting resumes from that value.
- R7: In AC mode (`ac_mode_i` = 1), only edges with `ac_strobe_i` high affect the disconnect timer, and `dc_under_i` is ignored. A sample with `ac_pass_i` = 0 advances the count, and the AC_LIMIT-th advance raises `disc_o`. Two consecutive strobes with `ac_pass_i` = 1 clear the count, while a single one does not.
- R8: While `port_on_i` is low, both timers are cleared and neither output pulses.
- R9: Each fault output is high for one cycle only. After a trip, no further pulse of that kind occurs until the port has been switched off and on again.
- R10: When the overload and disconnect timers expire on the same edge, only `ovl_fault_o` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_on_i | input | 1 | Port power is on |
| over_cut_i | input | 1 | Port current is above the cut threshold |
| dc_under_i | input | 1 | Port current is below the hold-current threshold (DC mode) |
| ac_strobe_i | input | 1 | One AC sense sample is valid this cycle |
| ac_pass_i | input | 1 | The AC sample saw the device present |
| ac_mode_i | input | 1 | 1 = AC sense, 0 = DC sense |
| pd_class_i | input | 3 | Latched power class, 0 to 4 |
| enforce_i | input | 1 | Enforce class-based cut threshold |
| ovl_fault_o | output | 1 | One-cycle overload turn-off request |
| disc_o | output | 1 | One-cycle disconnect turn-off request |
| cut_code_o | output | 2 | Cut-threshold code for the comparator |

## Verification
The threshold selector is driven with every class under both enforcement settings. This separates the enforced codes for classes 1 and 2 from the full-threshold fallback. The overload timer is given a run that is held long enough and a run that is broken one cycle short, which tells a restart apart from a count that only pauses. In DC mode, gaps in presence shorter than the filter and equal to it show whether the count is held or cleared. In AC mode, long stretches without strobes, single good samples and good pairs show whether strobes gate the timer and whether the pair rule holds. A coincident expiry of both timers and stimulus applied while the port is off check priority and the cleared state.

// File: rtl/psup_pkg.sv
package psup_pkg;

    typedef enum logic [1:0] {
        CUT_FULL = 2'b00,
        CUT_LOW  = 2'b01,
        CUT_MID  = 2'b10
    } cut_code_t;

    typedef enum logic [1:0] {
        OVL_OFF,
        OVL_ARMED,
        OVL_COUNT,
        OVL_TRIPPED
    } ovl_state_t;

    typedef enum logic [2:0] {
        MPS_OFF,
        MPS_PRESENT,
        MPS_ABSENT,
        MPS_REGAIN,
        MPS_TRIPPED
    } mps_state_t;

endpackage

// File: rtl/psup_cut_select.sv
module psup_cut_select
    import psup_pkg::*;
(
    input  logic [2:0] pd_class_i,
    input  logic       enforce_i,
    output cut_code_t  cut_code_o
);
    always_comb begin
        cut_code_o = CUT_FULL;
        if (enforce_i) begin
            unique case (pd_class_i)
                3'd1:    cut_code_o = CUT_LOW;
                3'd2:    cut_code_o = CUT_MID;
                default: cut_code_o = CUT_FULL;
            endcase
        end
    end
endmodule

// File: rtl/psup_ovl_timer.sv
module psup_ovl_timer
    import psup_pkg::*;
#(
    parameter int unsigned OVL_LIMIT = 62000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic port_on_i,
    input  logic over_i,
    output logic fault_o
);
    localparam int unsigned CW = $clog2(OVL_LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(OVL_LIMIT - 1);

    ovl_state_t    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          fire;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        fire  = 1'b0;
        unique case (st_q)
            OVL_OFF: begin
                cnt_d = '0;
                st_d  = OVL_ARMED;
            end
            OVL_ARMED: begin
                if (over_i) begin
                    cnt_d = CW'(1);
                    st_d  = OVL_COUNT;
                end
            end
            OVL_COUNT: begin
                if (!over_i) begin
                    cnt_d = '0;
                    st_d  = OVL_ARMED;
                end else if (cnt_q >= LAST) begin
                    fire = 1'b1;
                    st_d = OVL_TRIPPED;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            OVL_TRIPPED: st_d = OVL_TRIPPED;
            default:     st_d = OVL_OFF;
        endcase
        if (!port_on_i) begin
            st_d  = OVL_OFF;
            cnt_d = '0;
            fire  = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q  <= OVL_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fault_o <= 1'b0;
        else         fault_o <= fire;
    end
endmodule

// File: rtl/psup_mps_timer.sv
module psup_mps_timer
    import psup_pkg::*;
#(
    parameter int unsigned DC_LIMIT        = 350000,
    parameter int unsigned AC_LIMIT        = 38,
    parameter int unsigned PRESENCE_CYCLES = 20000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic port_on_i,
    input  logic ac_mode_i,
    input  logic dc_under_i,
    input  logic ac_strobe_i,
    input  logic ac_pass_i,
    output logic disc_o
);
    localparam int unsigned MAXL = (DC_LIMIT > AC_LIMIT) ? DC_LIMIT : AC_LIMIT;
    localparam int unsigned CW   = $clog2(MAXL + 1);
    localparam int unsigned MAXF = (PRESENCE_CYCLES > 2) ? PRESENCE_CYCLES : 2;
    localparam int unsigned FW   = $clog2(MAXF + 1);

    mps_state_t    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [FW-1:0] pres_q, pres_d;
    logic          fire;
    logic          absent_step, present_step;
    logic [CW-1:0] lim_last;
    logic [FW-1:0] need_last;

    // Sense source: per-clock DC flag or strobed AC samples
    always_comb begin
        if (ac_mode_i) begin
            absent_step  = ac_strobe_i & ~ac_pass_i;
            present_step = ac_strobe_i &  ac_pass_i;
            lim_last     = CW'(AC_LIMIT - 1);
            need_last    = FW'(1);
        end else begin
            absent_step  = dc_under_i;
            present_step = ~dc_under_i;
            lim_last     = CW'(DC_LIMIT - 1);
            need_last    = FW'(PRESENCE_CYCLES - 1);
        end
    end

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        pres_d = pres_q;
        fire   = 1'b0;
        unique case (st_q)
            MPS_OFF: begin
                cnt_d  = '0;
                pres_d = '0;
                st_d   = MPS_PRESENT;
            end
            MPS_PRESENT: begin
                if (absent_step) begin
                    cnt_d = CW'(1);
                    st_d  = MPS_ABSENT;
                end
            end
            MPS_ABSENT, MPS_REGAIN: begin
                if (absent_step) begin
                    pres_d = '0;
                    if (cnt_q >= lim_last) begin
                        fire = 1'b1;
                        st_d = MPS_TRIPPED;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                        st_d  = MPS_ABSENT;
                    end
                end else if (present_step) begin
                    if (st_q == MPS_REGAIN && pres_q >= need_last) begin
                        cnt_d  = '0;
                        pres_d = '0;
                        st_d   = MPS_PRESENT;
                    end else begin
                        pres_d = pres_q + FW'(1);
                        st_d   = MPS_REGAIN;
                    end
                end
            end
            MPS_TRIPPED: st_d = MPS_TRIPPED;
            default:     st_d = MPS_OFF;
        endcase
        if (!port_on_i) begin
            st_d   = MPS_OFF;
            cnt_d  = '0;
            pres_d = '0;
            fire   = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q   <= MPS_OFF;
            cnt_q  <= '0;
            pres_q <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            pres_q <= pres_d;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) disc_o <= 1'b0;
        else         disc_o <= fire;
    end
endmodule

// File: rtl/psup_top.sv
module psup_top
    import psup_pkg::*;
#(
    parameter int unsigned OVL_LIMIT       = 62000,
    parameter int unsigned DC_LIMIT        = 350000,
    parameter int unsigned AC_LIMIT        = 38,
    parameter int unsigned PRESENCE_CYCLES = 20000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       port_on_i,
    input  logic       over_cut_i,
    input  logic       dc_under_i,
    input  logic       ac_strobe_i,
    input  logic       ac_pass_i,
    input  logic       ac_mode_i,
    input  logic [2:0] pd_class_i,
    input  logic       enforce_i,
    output logic       ovl_fault_o,
    output logic       disc_o,
    output logic [1:0] cut_code_o
);
    cut_code_t cut_code;
    logic      ovl_pulse, mps_pulse;

    psup_cut_select u_cut (
        .pd_class_i (pd_class_i),
        .enforce_i  (enforce_i),
        .cut_code_o (cut_code)
    );

    psup_ovl_timer #(.OVL_LIMIT(OVL_LIMIT)) u_ovl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .port_on_i (port_on_i),
        .over_i    (over_cut_i),
        .fault_o   (ovl_pulse)
    );

    psup_mps_timer #(
        .DC_LIMIT        (DC_LIMIT),
        .AC_LIMIT        (AC_LIMIT),
        .PRESENCE_CYCLES (PRESENCE_CYCLES)
    ) u_mps (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .port_on_i   (port_on_i),
        .ac_mode_i   (ac_mode_i),
        .dc_under_i  (dc_under_i),
        .ac_strobe_i (ac_strobe_i),
        .ac_pass_i   (ac_pass_i),
        .disc_o      (mps_pulse)
    );

    // Overload wins a same-cycle expiry
    assign ovl_fault_o = ovl_pulse;
    assign disc_o      = mps_pulse & ~ovl_pulse;
    assign cut_code_o  = cut_code;
endmodule

// File: rtl/psup_checker.sv
module psup_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       port_on_i,
    input logic       over_cut_i,
    input logic       dc_under_i,
    input logic       ac_strobe_i,
    input logic       ac_pass_i,
    input logic       ac_mode_i,
    input logic       enforce_i,
    input logic       ovl_fault_o,
    input logic       disc_o,
    input logic [1:0] cut_code_o
);
    assert_cut_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enforce_i |-> cut_code_o == 2'b00);

    assert_ovl_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovl_fault_o |-> $past(over_cut_i));

    assert_dc_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (disc_o && $past(!ac_mode_i)) |-> $past(dc_under_i));

    assert_ac_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (disc_o && $past(ac_mode_i)) |-> $past(ac_strobe_i && !ac_pass_i));

    assert_off_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !port_on_i |=> (!ovl_fault_o && !disc_o));

    assert_ovl_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovl_fault_o |=> !ovl_fault_o);

    assert_disc_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        disc_o |=> !disc_o);

    assert_priority_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ovl_fault_o && disc_o));
endmodule

bind psup_top psup_checker u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .port_on_i   (port_on_i),
    .over_cut_i  (over_cut_i),
    .dc_under_i  (dc_under_i),
    .ac_strobe_i (ac_strobe_i),
    .ac_pass_i   (ac_pass_i),
    .ac_mode_i   (ac_mode_i),
    .enforce_i   (enforce_i),
    .ovl_fault_o (ovl_fault_o),
    .disc_o      (disc_o),
    .cut_code_o  (cut_code_o)
);

// File: tb/psup_top_bench.sv
module psup_top_bench;
    localparam int OVL = 20;
    localparam int DCL = 40;
    localparam int ACL = 6;
    localparam int PRS = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_on = 1'b0, over = 1'b0, under = 1'b0;
    logic       strobe = 1'b0, pass = 1'b0, mode = 1'b0, enf = 1'b0;
    logic [2:0] cls = 3'd0;
    logic       ovl, disc;
    logic [1:0] code;

    int errors = 0, checks = 0;
    int ovl_seen = 0, disc_seen = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    psup_top #(.OVL_LIMIT(OVL), .DC_LIMIT(DCL), .AC_LIMIT(ACL),
               .PRESENCE_CYCLES(PRS)) u_psup_top (
        .clk_i(clk), .rst_ni(rst_n), .port_on_i(port_on), .over_cut_i(over),
        .dc_under_i(under), .ac_strobe_i(strobe), .ac_pass_i(pass),
        .ac_mode_i(mode), .pd_class_i(cls), .enforce_i(enf),
        .ovl_fault_o(ovl), .disc_o(disc), .cut_code_o(code));

    always @(negedge clk) begin
        if (ovl)  ovl_seen  <= ovl_seen + 1;
        if (disc) disc_seen <= disc_seen + 1;
    end

    // {enforce, class[2:0], expected code[1:0]}
    localparam logic [5:0] CUT_VEC [10] = '{
        6'b100000, 6'b100101, 6'b101010, 6'b101100, 6'b110000,
        6'b000000, 6'b000100, 6'b001000, 6'b001100, 6'b010000
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic port_cycle();
        port_on = 1'b0; over = 1'b0; under = 1'b0; strobe = 1'b0;
        wait_n(2);
        port_on = 1'b1;
        wait_n(2);
    endtask

    task automatic ac_sample(input bit p);
        strobe = 1'b1; pass = p;
        wait_n(1);
        strobe = 1'b0;
        wait_n(3);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        wait_n(100000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int base_o, base_d;
        wait_n(3);
        check(ovl == 1'b0 && disc == 1'b0, "R8 reset outputs", {ovl, disc}, 0);
        rst_n = 1'b1;
        wait_n(2);
        check(ovl == 1'b0 && disc == 1'b0, "R8 idle after reset", {ovl, disc}, 0);

        // R1 / R2 threshold table
        for (int i = 0; i < 10; i++) begin
            enf = CUT_VEC[i][5];
            cls = CUT_VEC[i][4:2];
            #1;
            check(code == CUT_VEC[i][1:0], enf ? "R1 cut code" : "R2 cut code",
                  code, CUT_VEC[i][1:0]);
            wait_n(1);
        end

        // R8: stimulus while port off
        mode = 1'b0; over = 1'b1; under = 1'b1;
        wait_n(60);
        check(ovl_seen == 0 && disc_seen == 0, "R8 off ignores stimulus",
              ovl_seen + disc_seen, 0);
        port_cycle();

        // R3 overload expiry and R9 single pulse
        over = 1'b1;
        wait_n(OVL - 1);
        check(ovl == 1'b0, "R3 no fault one early", ovl, 0);
        wait_n(1);
        check(ovl == 1'b1, "R3 fault at limit", ovl, 1);
        wait_n(1);
        check(ovl == 1'b0, "R9 fault one cycle", ovl, 0);
        wait_n(40);
        check(ovl_seen == 1, "R9 no repeat while tripped", ovl_seen, 1);
        port_cycle();

        // R4 broken run restarts
        over = 1'b1;
        wait_n(15);
        over = 1'b0;
        wait_n(1);
        over = 1'b1;
        wait_n(OVL - 1);
        check(ovl == 1'b0 && ovl_seen == 1, "R4 restart needs full run", ovl_seen, 1);
        wait_n(1);
        check(ovl == 1'b1, "R4 fault after fresh run", ovl, 1);
        port_cycle();

        // R5 DC disconnect
        mode = 1'b0; under = 1'b1;
        wait_n(DCL - 1);
        check(disc == 1'b0, "R5 no disconnect one early", disc, 0);
        wait_n(1);
        check(disc == 1'b1, "R5 disconnect at limit", disc, 1);
        wait_n(50);
        check(disc_seen == 1, "R9 single disconnect", disc_seen, 1);
        port_cycle();

        // R6 short presence holds the count
        under = 1'b1; wait_n(30);
        under = 1'b0; wait_n(PRS - 3);
        under = 1'b1; wait_n(9);
        check(disc == 1'b0, "R6 held count early", disc, 0);
        wait_n(1);
        check(disc == 1'b1, "R6 held count resumes", disc, 1);
        port_cycle();

        // R6 full presence clears the count
        under = 1'b1; wait_n(30);
        under = 1'b0; wait_n(PRS);
        under = 1'b1; wait_n(DCL - 1);
        check(disc == 1'b0, "R6 cleared after filter", disc, 0);
        wait_n(1);
        check(disc == 1'b1, "R6 full count after clear", disc, 1);
        port_cycle();

        // R7 AC mode
        mode = 1'b1; under = 1'b1;
        base_d = disc_seen;
        wait_n(100);
        check(disc_seen == base_d, "R7 no strobe no count", disc_seen, base_d);
        for (int i = 0; i < ACL - 1; i++) ac_sample(1'b0);
        check(disc_seen == base_d, "R7 below sample limit", disc_seen, base_d);
        ac_sample(1'b0);
        check(disc_seen == base_d + 1, "R7 trip at sample limit", disc_seen, base_d + 1);
        port_cycle(); under = 1'b1;

        base_d = disc_seen;
        for (int i = 0; i < 4; i++) ac_sample(1'b0);
        ac_sample(1'b1);
        ac_sample(1'b0);
        check(disc_seen == base_d, "R7 single good sample", disc_seen, base_d);
        ac_sample(1'b0);
        check(disc_seen == base_d + 1, "R7 single good does not clear", disc_seen, base_d + 1);
        port_cycle(); under = 1'b1;

        base_d = disc_seen;
        for (int i = 0; i < 4; i++) ac_sample(1'b0);
        ac_sample(1'b1);
        ac_sample(1'b1);
        for (int i = 0; i < ACL - 1; i++) ac_sample(1'b0);
        check(disc_seen == base_d, "R7 good pair clears", disc_seen, base_d);
        ac_sample(1'b0);
        check(disc_seen == base_d + 1, "R7 full count after pair", disc_seen, base_d + 1);
        port_cycle();

        // R10 coincident expiry
        mode = 1'b0;
        base_o = ovl_seen; base_d = disc_seen;
        under = 1'b1;
        wait_n(DCL - OVL);
        over = 1'b1;
        wait_n(OVL - 1);
        check(ovl == 1'b0 && disc == 1'b0, "R10 nothing early", {ovl, disc}, 0);
        wait_n(1);
        check(ovl == 1'b1 && disc == 1'b0, "R10 overload wins", {ovl, disc}, 2);
        wait_n(30);
        check(ovl_seen == base_o + 1 && disc_seen == base_d, "R10 no late disconnect",
              disc_seen, base_d);
        port_cycle();

        finish_run();
    end
endmodule